// File: doc/BRIEF.md
# Reloading 16-bit Interval Timer

This block is a 16-bit down-counter paired with a 16-bit reload latch. It advances only on cycles where a clock-enable tick input is high, so it can run from a slow peripheral tick derived from the fast system clock. Software reaches it through a byte-wide register port with four addresses. A write to the counter's upper byte loads the counter and starts it. The counter passes through zero and then all-ones. In continuous mode it then reloads from the latch. In single-shot mode it keeps wrapping without further events.

Each qualifying underflow produces a one-cycle `flag_set` pulse for an interrupt-flag register that lives elsewhere. A start, or a read of the counter's lower byte, produces a one-cycle `flag_clr` pulse for the same register. A 2-bit mode input selects continuous reload and enables a square-wave output pin.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter and both latch bytes read 0, `wave_out` is 1, and `flag_set` and `flag_clr` are 0.
- R2: A write to address 2 or address 0 sets the latch lower byte, and a write to address 3 sets the latch upper byte. Reads of addresses 2 and 3 return the latch lower and upper bytes. Read data appears on `rdata` the cycle after `rd_en`.
- R3: A write of value D to address 1 loads the counter with {D, latch lower byte}, sets the latch upper byte to D, and pulses `flag_clr` one cycle later. Addresses 0 and 1 read the counter lower and upper bytes.
- R4: The counter changes only on cycles where `tick` is high or a start write occurs.
- R5: After a start with count N, the first `flag_set` pulse follows N+1 ticks, and the counter then holds 0xFFFF, so its upper byte reads 0xFF.
- R6: In continuous mode (`mode[0]`=1), successive `flag_set` pulses are spaced latch+2 ticks apart.
- R7: In single-shot mode (`mode[0]`=0), only the first underflow after a start pulses `flag_set`. Later wraps produce no pulse.
- R8: A read of address 0 pulses `flag_clr` one cycle later. Reads of other addresses do not.
- R9: With `mode[1]`=1 in continuous mode, `wave_out` toggles on every underflow.
- R10: With `mode[1]`=1 in single-shot mode, `wave_out` goes to 0 on a start and returns to 1 on the first underflow.
- R11: With `mode[1]`=0, `wave_out` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable; the counter steps on cycles where it is high |
| mode | input | 2 | Bit 1: square-wave output enable; bit 0: continuous reload |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 counter low, 1 counter high / start, 2 latch low, 3 latch high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| flag_set | output | 1 | One-cycle pulse on a qualifying underflow |
| flag_clr | output | 1 | One-cycle pulse on a start or a counter-low read |
| wave_out | output | 1 | Square-wave / single-shot output pin |

## Verification
A wrong counter or reload state shows as a `flag_set` spacing that differs from latch+2 ticks. That error is visible at the second underflow, within one period. A stuck reload-pending bit or armed bit shows either as a missing pulse or as extra pulses during the 65536-tick wrap in single-shot mode. A bad latch or byte mux shows as wrong read data one cycle after the read strobe. A wave register that fails to follow underflows differs at the first pulse.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    A_CNT_LO = 2'd0,
    A_CNT_HI = 2'd1,
    A_LAT_LO = 2'd2,
    A_LAT_HI = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] rdata,
  output logic [CNT_W-1:0]  latch,
  output logic              start,
  output logic              flag_clr
);
  logic [BYTE_W-1:0] lat_lo, lat_hi;
  reg_addr_e ra;

  assign ra    = reg_addr_e'(addr);
  assign latch = {lat_hi, lat_lo};
  assign start = wr_en && (ra == A_CNT_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_lo <= '0;
      lat_hi <= '0;
    end else if (wr_en) begin
      case (ra)
        A_CNT_LO, A_LAT_LO: lat_lo <= wdata;
        A_CNT_HI, A_LAT_HI: lat_hi <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      flag_clr <= 1'b0;
    end else begin
      flag_clr <= start || (rd_en && ra == A_CNT_LO);
      if (rd_en) begin
        case (ra)
          A_CNT_LO: rdata <= cnt[BYTE_W-1:0];
          A_CNT_HI: rdata <= cnt[CNT_W-1:BYTE_W];
          A_LAT_LO: rdata <= lat_lo;
          default:  rdata <= lat_hi;
        endcase
      end
    end
  end

  // R8
  lowread_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd0) |=> flag_clr);
  // R3
  start_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd1) |=> flag_clr);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cont,
  input  logic              start,
  input  logic [BYTE_W-1:0] start_hi,
  input  logic [CNT_W-1:0]  latch,
  output logic [CNT_W-1:0]  cnt,
  output logic              uf,
  output logic              flag_set
);
  logic armed, pend;
  logic at_zero;

  assign at_zero = (cnt == '0);
  assign uf = tick && !start && !pend && at_zero && (cont || armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      armed    <= 1'b0;
      pend     <= 1'b0;
      flag_set <= 1'b0;
    end else begin
      flag_set <= uf;
      if (start) begin
        cnt   <= {start_hi, latch[BYTE_W-1:0]};
        armed <= 1'b1;
        pend  <= 1'b0;
      end else if (tick) begin
        if (pend) begin
          cnt  <= latch;
          pend <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
          if (at_zero) begin
            if (cont) pend <= 1'b1;
            else armed <= 1'b0;
          end
        end
      end
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start) |=> $stable(cnt));
  // R5
  wrap_value_chk: assert property (@(posedge clk) disable iff (rst)
    flag_set |-> (cnt == {CNT_W{1'b1}}));
  // R7
  single_once_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_set && !cont && !start) |=> !flag_set);
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave (
  input  logic clk,
  input  logic rst,
  input  logic wave_en,
  input  logic cont,
  input  logic start,
  input  logic uf,
  output logic wave_out
);
  always_ff @(posedge clk) begin
    if (rst || !wave_en) wave_out <= 1'b1;
    else if (start && !cont) wave_out <= 1'b0;
    else if (uf) wave_out <= cont ? ~wave_out : 1'b1;
  end

  // R11
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !wave_en |=> wave_out);
  // R10
  single_low_chk: assert property (@(posedge clk) disable iff (rst)
    (wave_en && !cont && start) |=> !wave_out);
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              flag_set,
  output logic              flag_clr,
  output logic              wave_out
);
  logic [CNT_W-1:0] cnt, latch;
  logic start, uf;

  tmr_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .rdata(rdata), .latch(latch),
    .start(start), .flag_clr(flag_clr)
  );

  tmr_core #(.BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .cont(mode[0]), .start(start),
    .start_hi(wdata), .latch(latch), .cnt(cnt), .uf(uf), .flag_set(flag_set)
  );

  tmr_wave u_wave (
    .clk(clk), .rst(rst), .wave_en(mode[1]), .cont(mode[0]),
    .start(start), .uf(uf), .wave_out(wave_out)
  );

  // R9
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && uf) |=> (wave_out != $past(wave_out)));
endmodule

// File: tb/reload_timer_test.sv
module reload_timer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [1:0] mode = 2'b00;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic flag_set, flag_clr, wave_out;

  int errors = 0, checks = 0, cyc = 0, div = 0, dcnt = 0;

  always #2.5 clk = ~clk;

  reload_timer uut (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .flag_set(flag_set), .flag_clr(flag_clr), .wave_out(wave_out)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick <= (div != 0) && (dcnt == 0);
    dcnt <= (div == 0 || dcnt + 1 >= div) ? 0 : dcnt + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, output logic c);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata; c = flag_clr;
  endtask

  task automatic wait_flag(output int n);
    n = 0;
    while (!flag_set && n < 70000) begin @(negedge clk); n++; end
  endtask

  // {latch[15:0], mode[1:0], tick divider[3:0]}
  localparam logic [21:0] VEC [5] = '{
    {16'd5,   2'b01, 4'd1},
    {16'd0,   2'b11, 4'd1},
    {16'd10,  2'b11, 4'd3},
    {16'd1,   2'b01, 4'd2},
    {16'd300, 2'b11, 4'd1}
  };

  initial begin
    logic [7:0] d;
    logic c;
    int n;
    logic w1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(wave_out && !flag_set && !flag_clr, "R1 outputs", {wave_out, flag_set, flag_clr}, 3'b100);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d, c);
      chk(d == 8'h00, "R1 register", d, 0);
    end
    // R2 latch writes and reads
    wr(2'd2, 8'h34); wr(2'd3, 8'h12);
    rd(2'd2, d, c); chk(d == 8'h34, "R2 latch lo", d, 8'h34);
    rd(2'd3, d, c); chk(d == 8'h12, "R2 latch hi", d, 8'h12);
    wr(2'd0, 8'h77); rd(2'd2, d, c); chk(d == 8'h77, "R2 addr0 write", d, 8'h77);
    wr(2'd2, 8'h34);
    // R3 start loads counter, R4 holds without tick
    wr(2'd1, 8'h56);
    chk(flag_clr, "R3 flag_clr on start", flag_clr, 1);
    repeat (10) @(negedge clk);
    rd(2'd1, d, c); chk(d == 8'h56, "R3 counter hi", d, 8'h56);
    rd(2'd3, d, c); chk(d == 8'h56, "R3 latch hi copy", d, 8'h56);
    rd(2'd0, d, c); chk(d == 8'h34, "R4 counter lo held", d, 8'h34);
    // R8 counter-low read clears, others do not
    chk(c, "R8 clr on low read", c, 1);
    rd(2'd1, d, c); chk(!c, "R8 no clr on high read", c, 0);
    rd(2'd3, d, c); chk(!c, "R8 no clr on latch read", c, 0);
    // R5 first underflow latency and value
    mode = 2'b00; div = 1;
    wr(2'd2, 8'd3);
    wr(2'd1, 8'd0);
    wait_flag(n);
    div = 0;
    chk(n == 4, "R5 latency", n, 4);
    @(negedge clk);
    rd(2'd1, d, c); chk(d == 8'hFF, "R5 high after wrap", d, 8'hFF);
    // R7 single-shot: no further pulse over a full wrap
    div = 1; n = 0;
    repeat (65600) begin @(negedge clk); if (flag_set) n++; end
    div = 0;
    chk(n == 0, "R7 extra pulses", n, 0);
    // R10 single-shot wave
    mode = 2'b10; div = 1;
    wr(2'd2, 8'd6);
    wr(2'd1, 8'd0);
    chk(!wave_out, "R10 low on start", wave_out, 0);
    wait_flag(n);
    chk(wave_out, "R10 high on underflow", wave_out, 1);
    div = 0;
    // R6 / R9 / R11 vector walk
    for (int i = 0; i < 5; i++) begin
      logic [15:0] lat;
      int dv, exp;
      lat = VEC[i][21:6]; mode = VEC[i][5:4]; dv = VEC[i][3:0];
      div = dv;
      wr(2'd2, lat[7:0]);
      wr(2'd1, lat[15:8]);
      wait_flag(n);
      w1 = wave_out;
      @(negedge clk); n = 1;
      while (!flag_set && n < 70000) begin @(negedge clk); n++; end
      exp = (lat + 2) * dv;
      chk(n == exp, "R6 period", n, exp);
      if (mode[1]) chk(wave_out != w1, "R9 toggle", wave_out, !w1);
      else chk(wave_out && w1, "R11 wave idle", wave_out, 1);
      div = 0;
      repeat (3) @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule